// File: doc/BRIEF.md
# Receive Line Idle Timeout Timer

This block watches a serial receiver for silence. It counts bit periods and raises a sticky timeout flag when the programmed number of bit periods passes without a new character. Each received character reloads the count. The count is measured in ticks from a bit-period strobe. The timeout length comes from a programmable input. A value of zero turns the timer off.

There are two ways to start the timer. The arm command clears the flag and cancels any period that is running. The timer then waits for the first received character before it begins counting. The restart command reloads the count and starts counting at once. It does not wait for a character and it leaves the flag as it is. Once the flag is set, counting stops until a new command arrives.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `timeout_o` is 0 and `active_o` is 0.
- R2: An arm command clears `timeout_o` and stops any running period. After the clock edge that samples it, `active_o` is 0.
- R3: After an arm command, no tick counts until a character pulse arrives. The first character pulse after the arm starts counting. `active_o` is 1 from the next cycle.
- R4: A restart command with a non-zero timeout value loads that value and starts counting at once. `active_o` is 1 from the next cycle. Exactly that many later ticks set the flag.
- R5: A character pulse while counting reloads the full timeout value. A character pulse in the same cycle as a tick wins, and that tick is not counted.
- R6: The tick that brings the count to zero sets `timeout_o` and clears `active_o` in the same cycle. Later ticks and character pulses change neither output until a command arrives.
- R7: While the timeout value is 0, `active_o` is 0 from the next cycle. `timeout_o` never rises.
- R8: When arm and restart are sampled in the same cycle, arm takes effect and restart is ignored. `active_o` is 0 afterwards and the timer waits for a character.
- R9: `timeout_o` stays at 1 until an arm command. A restart command does not clear it.
- R10: A character pulse while the timer is neither waiting nor counting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Clear the flag and wait for the next character before counting |
| restart_i | input | 1 | Reload and start counting immediately |
| char_i | input | 1 | One-cycle pulse for each character received |
| tick_i | input | 1 | One-cycle strobe for each bit period |
| limit_i | input | CNT_W | Timeout length in bit periods; 0 disables the timer |
| timeout_o | output | 1 | Sticky timeout flag |
| active_o | output | 1 | High while the period is being counted |

## Verification
The bench sweeps timeout values from 1 to 6. For each value it predicts the exact tick on which the flag must rise.

A design with an off-by-one count would raise the flag one tick early or late. A design that forgot the wait-for-character state would time out on ticks that arrive between an arm command and the first character. A design that reloaded on a character after the timeout would start counting again without any command.

Further cases target the command rules. If restart cleared the flag, the flag would drop without an arm command. If the priority between arm and restart were inverted, `active_o` would be 1 after a cycle in which both commands arrive. If a zero timeout value were treated as the maximum count, the timer would run instead of staying off.

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             restart_i,
  input  logic             char_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, wait_q, flag_q;
  logic             off;
  logic             last;

  assign off  = (limit_i == '0);
  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wait_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (arm_i) begin
      flag_q <= 1'b0;
      run_q  <= 1'b0;
      wait_q <= 1'b1;
    end else if (off) begin
      run_q  <= 1'b0;
    end else if (restart_i || (char_i && (wait_q || run_q))) begin
      cnt_q  <= limit_i;
      run_q  <= 1'b1;
      wait_q <= 1'b0;
    end else if (run_q && tick_i) begin
      if (last) begin
        flag_q <= 1'b1;
        run_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign timeout_o = flag_q;
  assign active_o  = run_q;
endmodule

module rx_idle_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_i,
  input logic             restart_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             timeout_o,
  input logic             active_o
);
  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!timeout_o && !active_o));
  a_r4_restart_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !arm_i && limit_i != '0) |=> active_o);
  a_r6_stop_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> !active_o);
  a_r7_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |=> (!active_o && !$rose(timeout_o)));
  a_r8_arm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && restart_i) |=> !active_o);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !arm_i) |=> timeout_o);
endmodule

bind rx_idle_timer rx_idle_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .restart_i(restart_i),
  .limit_i(limit_i), .timeout_o(timeout_o), .active_o(active_o)
);

// File: tb/test_rx_idle_timer.sv
module test_rx_idle_timer;
  localparam int CNT_W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, rst_cmd = 0, chr = 0, tck = 0;
  logic [CNT_W-1:0] lim = '0;
  logic tmo, act;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rx_idle_timer #(.CNT_W(CNT_W)) i_rx_idle_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .restart_i(rst_cmd),
    .char_i(chr), .tick_i(tck), .limit_i(lim),
    .timeout_o(tmo), .active_o(act)
  );

  task automatic pulse(input logic a, input logic r, input logic c, input logic t);
    @(negedge clk);
    arm = a; rst_cmd = r; chr = c; tck = t;
    @(negedge clk);
    arm = 0; rst_cmd = 0; chr = 0; tck = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(0, 0, 0, 1);
  endtask

  task automatic chk(input string req, input logic et, input logic ea);
    n_chk++;
    if (tmo !== et || act !== ea) begin
      n_bad++;
      $display("FAIL %s: timeout=%b active=%b expected timeout=%b active=%b",
               req, tmo, act, et, ea);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    lim = 4'd3;
    repeat (3) @(negedge clk);
    chk("R1", 0, 0);
    rst_n = 1'b1;
    pulse(0, 0, 1, 0); ticks(10);
    chk("R10", 0, 0);

    for (int l = 1; l <= 6; l++) begin
      lim = CNT_W'(l);
      pulse(1, 0, 0, 0);        chk("R2", 0, 0);
      ticks(3 * l);             chk("R3", 0, 0);
      pulse(0, 0, 1, 0);        chk("R3", 0, 1);
      ticks(l - 1);             chk("R4", 0, 1);
      pulse(0, 0, 1, 1);        chk("R5", 0, 1);
      ticks(l - 1);             chk("R5", 0, 1);
      ticks(1);                 chk("R6", 1, 0);
      pulse(0, 0, 1, 0); ticks(l + 2); chk("R6", 1, 0);
      pulse(0, 1, 0, 0);        chk("R9", 1, 1);
      ticks(l);                 chk("R9", 1, 0);
      pulse(1, 0, 0, 0);        chk("R2", 0, 0);
      pulse(0, 1, 0, 0);        chk("R4", 0, 1);
      ticks(l - 1);             chk("R4", 0, 1);
      ticks(1);                 chk("R4", 1, 0);
      pulse(1, 1, 0, 0);        chk("R8", 0, 0);
      ticks(2 * l);             chk("R8", 0, 0);
      pulse(0, 0, 1, 0);        chk("R8", 0, 1);
      pulse(1, 0, 0, 0);        chk("R2", 0, 0);
    end

    lim = '0;
    pulse(0, 1, 0, 0);          chk("R7", 0, 0);
    pulse(0, 0, 1, 0); ticks(40); chk("R7", 0, 0);
    lim = 4'd5;
    pulse(0, 1, 0, 0);          chk("R4", 0, 1);
    lim = '0;
    ticks(1);                   chk("R7", 0, 0);
    ticks(20);                  chk("R7", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule